// File: doc/BRIEF.md
# I2C EEPROM Slave Model

This block behaves as a 2048-byte serial EEPROM on an I2C bus. It runs from a fast system clock. It passes both bus lines through two-flop synchronizers and finds clock edges, start conditions and stop conditions by comparing successive synchronized samples. The slave drives the data line only through a pull-low enable, which keeps the bus open-drain.

A transaction opens with a select byte. Its upper nibble is a fixed type tag, its next three bits give the top of the 11-bit memory address, and its last bit chooses read or write. A write then supplies a word address and up to a page of data. Data bytes are held in a page staging buffer and reach the storage only after a stop. For a set number of system clocks after that stop the slave ignores the bus, as a real cell programming cycle would. Reads come from an internal address counter. That counter survives between commands, so the block supports current-address, random and sequential reads.

A write-lock input protects the whole array. While it is high, select and address bytes are still acknowledged, but data bytes are not, and no programming cycle begins.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data pull-low enable is inactive and the address counter is 0, so a current-address read returns the byte stored at address 0.
- R2: A select byte whose bits 7..4 are not 1010 gets no acknowledge. The slave then ignores the bus, acknowledging nothing, until the next start.
- R3: A byte write (select with bit 0 = 0, word address, one data byte, stop) followed by a random read (select write, word address, repeated start, select with bit 0 = 1) returns the byte written.
- R4: In a page write, the lowest 4 address bits advance after each data byte and wrap within the 16-byte page. When more than 16 bytes are sent, the later bytes overwrite the earlier ones.
- R5: Data reaches storage only after a stop. A repeated start drops any staged bytes. From the stop until WRITE_CYCLES system clocks have passed, the slave acknowledges nothing.
- R6: While wr_lock is high, select and address bytes are acknowledged, data bytes are not, storage is unchanged, and a stop starts no busy period.
- R7: A sequential read advances the full 11-bit address after each byte and wraps from 2047 to 0. The next current-address read continues from the counter's value.
- R8: A read that the master ends with a no-acknowledge and a stop returns the slave to idle, and it acknowledges the next select at once. A master acknowledge makes the slave send the next byte.
- R9: Select bits 3..1 supply address bits 10..8, so two writes that share a word address but use different select bits reach different cells.
- R10: The pull-low enable only turns on while the synchronized SCL is low, and a start and a stop are never detected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired value) |
| wr_lock | input | 1 | High blocks all writes to storage; tie low to allow writes |
| sda_pull | output | 1 | High pulls the data line low; low releases it |

## Verification
A wrong bit counter or a wrong state shows up within one byte time as a missing or misplaced acknowledge, seen on the next ninth clock. A corrupt address counter or a bad page-index wrap shows up only at the next read, as data taken from the wrong cell. A staging or commit fault waits until the programming cycle has ended and the cell is read back. For this reason every write in the bench is followed by a readback, and the busy window is probed both immediately after the stop and after it has expired.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DW,
        ST_ACK_DR,
        ST_WADR,
        ST_ACK_ADR,
        ST_WDAT,
        ST_ACK_DAT,
        ST_RDAT,
        ST_RACK,
        ST_BUSY
    } ee_state_e;

    localparam logic [3:0] SEL_TAG = 4'b1010;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic tag_hit(input logic [7:0] b);
        return b[7:4] == SEL_TAG;
    endfunction

endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output ee_pkg::line_ev_t  ev
);
    logic [2:0] scl_sh;
    logic [2:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[1:0], scl_in};
            sda_sh <= {sda_sh[1:0], sda_in};
        end
    end

    always_comb begin
        ev.scl   = scl_sh[1];
        ev.sda   = sda_sh[1];
        ev.rise  = scl_sh[1] & ~scl_sh[2];
        ev.fall  = ~scl_sh[1] & scl_sh[2];
        ev.start = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
        ev.stop  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
    end

    // R10
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int BYTES = 16,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr,
    input  logic [IW-1:0]    widx,
    input  logic [7:0]       wdata,
    input  logic [IW-1:0]    ridx,
    output logic [7:0]       rdata,
    output logic [BYTES-1:0] vmask
);
    logic [7:0] slot [BYTES];

    always_ff @(posedge clk) begin
        if (rst || clr) vmask <= '0;
        else if (wr)    vmask[widx] <= 1'b1;
        if (wr) slot[widx] <= wdata;
    end

    assign rdata = slot[ridx];

    // R4
    pb_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr) |=> vmask[$past(widx)]);

endmodule

// File: rtl/ee_store.sv
module ee_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
    parameter int ADDR_W       = 11,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wr_lock,
    output logic sda_pull
);
    import ee_pkg::*;

    localparam int PW   = $clog2(PAGE_BYTES);
    localparam int CW   = $clog2(WRITE_CYCLES + 1);
    localparam int HI_W = ADDR_W - 8;

    line_ev_t             ev;
    ee_state_e            st;
    logic [3:0]           bitcnt;
    logic                 got8;
    logic [7:0]           shreg;
    logic [6:0]           txs;
    logic [HI_W-1:0]      hi_sel;
    logic [ADDR_W-1:0]    addr;
    logic                 mack;
    logic [CW-1:0]        cyc;
    logic                 pull;

    logic                 pb_wr, pb_clr;
    logic [PW-1:0]        cidx;
    logic [7:0]           pb_rdata, mem_rdata;
    logic [PAGE_BYTES-1:0] vmask;
    logic                 mem_we;

    ee_line_sync u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    always_comb begin
        cidx   = cyc[PW-1:0];
        pb_wr  = ev.fall && got8 && (st == ST_WDAT) && !wr_lock;
        pb_clr = (ev.start && st != ST_BUSY) ||
                 (st == ST_BUSY && cyc == CW'(WRITE_CYCLES - 1));
        mem_we = (st == ST_BUSY) && (cyc < CW'(PAGE_BYTES)) && vmask[cidx];
    end

    ee_page_buf #(.BYTES(PAGE_BYTES), .IW(PW)) u_page (
        .clk(clk), .rst(rst), .clr(pb_clr), .wr(pb_wr),
        .widx(addr[PW-1:0]), .wdata(shreg), .ridx(cidx),
        .rdata(pb_rdata), .vmask(vmask)
    );

    ee_store #(.AW(ADDR_W), .DW(8)) u_store (
        .clk(clk), .we(mem_we), .waddr({addr[ADDR_W-1:PW], cidx}),
        .wdata(pb_rdata), .raddr(addr), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; bitcnt <= '0; got8 <= 1'b0; shreg <= '0;
            txs <= '0; hi_sel <= '0; addr <= '0; mack <= 1'b0;
            cyc <= '0; pull <= 1'b0;
        end else if (st == ST_BUSY) begin
            pull <= 1'b0;
            if (cyc == CW'(WRITE_CYCLES - 1)) begin
                cyc <= '0;
                st  <= ST_IDLE;
            end else begin
                cyc <= cyc + CW'(1);
            end
        end else if (ev.start) begin
            st <= ST_DEV; bitcnt <= '0; got8 <= 1'b0; pull <= 1'b0;
        end else if (ev.stop) begin
            pull <= 1'b0;
            cyc  <= '0;
            st   <= (|vmask) ? ST_BUSY : ST_IDLE;
        end else begin
            if (ev.rise) begin
                case (st)
                    ST_DEV, ST_WADR, ST_WDAT: begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) got8 <= 1'b1;
                    end
                    ST_RDAT: bitcnt <= bitcnt + 4'd1;
                    ST_RACK: mack <= ~ev.sda;
                    default: ;
                endcase
            end
            if (ev.fall) begin
                case (st)
                    ST_DEV: if (got8) begin
                        got8 <= 1'b0; bitcnt <= '0;
                        if (tag_hit(shreg)) begin
                            hi_sel <= shreg[HI_W:1];
                            pull   <= 1'b1;
                            st     <= shreg[0] ? ST_ACK_DR : ST_ACK_DW;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_WADR: if (got8) begin
                        got8 <= 1'b0; bitcnt <= '0;
                        addr <= {hi_sel, shreg};
                        pull <= 1'b1;
                        st   <= ST_ACK_ADR;
                    end
                    ST_WDAT: if (got8) begin
                        got8 <= 1'b0; bitcnt <= '0;
                        if (!wr_lock) begin
                            pull           <= 1'b1;
                            addr[PW-1:0]   <= addr[PW-1:0] + PW'(1);
                        end
                        st <= ST_ACK_DAT;
                    end
                    ST_ACK_DW: begin pull <= 1'b0; st <= ST_WADR; end
                    ST_ACK_ADR, ST_ACK_DAT: begin pull <= 1'b0; st <= ST_WDAT; end
                    ST_ACK_DR: begin
                        txs <= mem_rdata[6:0]; pull <= ~mem_rdata[7];
                        bitcnt <= '0; st <= ST_RDAT;
                    end
                    ST_RDAT: begin
                        if (bitcnt == 4'd8) begin
                            pull <= 1'b0; st <= ST_RACK;
                            addr <= addr + ADDR_W'(1);
                        end else begin
                            pull <= ~txs[6];
                            txs  <= {txs[5:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        if (mack) begin
                            txs <= mem_rdata[6:0]; pull <= ~mem_rdata[7];
                            bitcnt <= '0; st <= ST_RDAT;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = pull;

    // R10
    pull_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl);

    // R5
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY) |-> !sda_pull);

    // R5
    busy_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_BUSY) |-> ($past(vmask) != '0));

    // R5
    cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
        cyc < CW'(WRITE_CYCLES));

    // R2
    sel_ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK_DW || st == ST_ACK_DR) |-> sda_pull);

endmodule

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
    localparam int WC = 300;
    localparam int H  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic lock = 1'b0;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    int n_cmp = 0;
    int n_bad = 0;
    int viol  = 0;
    logic prev_pull = 1'b0;

    logic [8:0] exp_v[$];
    string      exp_r[$];
    logic [8:0] obs_v[$];

    logic [7:0] wbuf [0:31];
    logic [7:0] rexp [0:31];

    always #2.5 clk = ~clk;

    i2c_eeprom_slave #(.ADDR_W(11), .PAGE_BYTES(16), .WRITE_CYCLES(WC)) u0 (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .wr_lock(lock), .sda_pull(sda_pull)
    );

    // Scoreboard monitor: pops observed items and compares with expected.
    always @(negedge clk) begin
        if (obs_v.size() != 0) begin
            logic [8:0] o, e;
            string r;
            o = obs_v.pop_front();
            n_cmp++;
            if (exp_v.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected item actual=%h expected=none", o);
            end else begin
                e = exp_v.pop_front();
                r = exp_r.pop_front();
                if (o !== e) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", r, o, e);
                end
            end
        end
    end

    // R10 watcher: pull-low must only begin while SCL is low.
    always @(negedge clk) begin
        if (!rst && sda_pull && !prev_pull && scl_m) viol++;
        prev_pull <= sda_pull;
    end

    task automatic push_exp(input logic [8:0] v, input string r);
        exp_v.push_back(v);
        exp_r.push_back(r);
    endtask

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; hw(); scl_m = 1'b1; hw(); s = sda_line; scl_m = 1'b0; hw();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string r);
        logic s;
        push_exp({1'b1, 7'd0, exp_ack}, r);
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        obs_v.push_back({1'b1, 7'd0, ~s});
    endtask

    task automatic recv_byte(input logic give_ack, input logic [7:0] e, input string r);
        logic s;
        logic [7:0] b;
        push_exp({1'b0, e}, r);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
        obs_v.push_back({1'b0, b});
    endtask

    task automatic sel(input logic [10:0] a, input logic rd, input logic ack, input string r);
        send_byte({4'b1010, a[10:8], rd}, ack, r);
    endtask

    task automatic wait_wc();
        repeat (WC + 60) @(negedge clk);
    endtask

    task automatic write_bytes(input logic [10:0] a, input int n, input logic dack, input string r);
        i2c_start();
        sel(a, 1'b0, 1'b1, r);
        send_byte(a[7:0], 1'b1, r);
        for (int i = 0; i < n; i++) send_byte(wbuf[i], dack, r);
        i2c_stop();
    endtask

    task automatic write1(input logic [10:0] a, input logic [7:0] d, input string r);
        wbuf[0] = d;
        write_bytes(a, 1, 1'b1, r);
        wait_wc();
    endtask

    task automatic read_rand(input logic [10:0] a, input int n, input string r);
        i2c_start();
        sel(a, 1'b0, 1'b1, r);
        send_byte(a[7:0], 1'b1, r);
        i2c_start();
        sel(a, 1'b1, 1'b1, r);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rexp[i], r);
        i2c_stop();
    endtask

    task automatic read_cur(input logic [7:0] e, input string r);
        i2c_start();
        sel(11'd0, 1'b1, 1'b1, r);
        recv_byte(1'b0, e, r);
        i2c_stop();
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_cmp++;
        if (sda_pull !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset pull actual=%b expected=0", sda_pull);
        end

        // R1: counter back to 0 after reset
        write1(11'h000, 8'hA5, "R3");
        write1(11'h001, 8'h5A, "R3");
        write1(11'h123, 8'h3C, "R3");
        @(negedge clk); rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
        read_cur(8'hA5, "R1");

        // R2: wrong tag gets no ack, following byte ignored
        i2c_start();
        send_byte(8'hB0, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        i2c_stop();

        // R3 and R9: upper bits from select byte
        write1(11'h2A7, 8'h35, "R9");
        write1(11'h0A7, 8'h77, "R9");
        rexp[0] = 8'h35; read_rand(11'h2A7, 1, "R3");
        rexp[0] = 8'h77; read_rand(11'h0A7, 1, "R9");

        // R4: page write wrap, 18 bytes from offset 14
        for (int i = 0; i < 18; i++) wbuf[i] = 8'h40 + 8'(i);
        write_bytes(11'h10E, 18, 1'b1, "R4");
        wait_wc();
        for (int k = 0; k < 14; k++) rexp[k] = 8'h42 + 8'(k);
        rexp[14] = 8'h50; rexp[15] = 8'h51;
        read_rand(11'h100, 16, "R4");

        // R5: busy window and commit only after stop
        write1(11'h055, 8'h11, "R5");
        wbuf[0] = 8'h99;
        write_bytes(11'h055, 1, 1'b1, "R5");
        i2c_start();
        sel(11'h000, 1'b1, 1'b0, "R5");
        i2c_stop();
        wait_wc();
        rexp[0] = 8'h99; read_rand(11'h055, 1, "R5");
        i2c_start();
        sel(11'h055, 1'b0, 1'b1, "R5");
        send_byte(8'h55, 1'b1, "R5");
        send_byte(8'hEE, 1'b1, "R5");
        rexp[0] = 8'h99; read_rand(11'h055, 1, "R5");
        i2c_start();
        sel(11'h000, 1'b0, 1'b1, "R5");
        i2c_stop();

        // R6: write lock
        lock = 1'b1;
        wbuf[0] = 8'h12;
        write_bytes(11'h055, 1, 1'b0, "R6");
        i2c_start();
        sel(11'h000, 1'b0, 1'b1, "R6");
        i2c_stop();
        lock = 1'b0;
        rexp[0] = 8'h99; read_rand(11'h055, 1, "R6");

        // R7: sequential wrap then current-address continuation
        write1(11'h7FF, 8'hC1, "R7");
        rexp[0] = 8'hC1; rexp[1] = 8'hA5;
        read_rand(11'h7FF, 2, "R7");
        read_cur(8'h5A, "R7");

        // R8: immediate ack after NACK + stop
        rexp[0] = 8'h3C; read_rand(11'h123, 1, "R8");

        drain();
        n_cmp++;
        if (viol != 0) begin
            n_bad++;
            $display("FAIL R10 pull rises with SCL high actual=%0d expected=0", viol);
        end
        n_cmp++;
        if (exp_v.size() != 0) begin
            n_bad++;
            $display("FAIL leftover expectations actual=%0d expected=0", exp_v.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(negedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule